// File: doc/BRIEF.md
# Row-Buffered DRAM Array Controller

This block fronts a behavioural DRAM bit array whose rows are read destructively. A host opens a row by placing the row index on a shared, multiplexed address bus and pulsing `rasStrobe`. It then selects a word within that row by placing the column index on the same bus and pulsing `casStrobe`, together with a read/write flag and write data. The controller copies the whole row into a row buffer, which empties that row in the array. It serves the selected word: a read drives it out, and a write merges the new word into the buffer. It then writes the full buffer back to the array before it accepts anything new.

A refresh engine runs alongside host traffic. A free-running interval counter marks a refresh as due. At the next idle point the engine loads the next row in sequence into the buffer and writes it back, so every row is visited in turn whether the host touches it or not. A refresh never breaks into an access that has already started. When a refresh is due, it wins over a new host row strobe.

With the full configuration (`ROW_W`=12, `COL_W`=10, `DATA_W`=4) a 24-bit word-select address splits as follows. Bits [23:12] pick one of 4096 rows. Bits [11:2] pick one of 1024 four-bit columns in a 4096-bit row. Each data bit comes from its own 1024-to-1 multiplexer. The defaults are smaller so that the behavioural array stays light.

Top module: `dram_rb_top`

## Requirements
- R1: After reset, `hostReady` is 1 and `rdValid` is 0.
- R2: `muxAddr[ROW_W-1:0]` is captured as the row when `rasStrobe` is high on an edge where `hostReady` is 1 in the idle state. `muxAddr[COL_W-1:0]` is captured as the column when `casStrobe` is high while the row is open. A read of column c returns row-buffer bits [c*DATA_W +: DATA_W].
- R3: Loading a row into the buffer clears it in the array, and the buffer is always written back before any other row is loaded. Reading the same word twice returns the same value.
- R4: A write changes only the DATA_W bits of the addressed column. Every other column of that row keeps its value.
- R5: A read raises `rdValid` for exactly one cycle, the second cycle after the edge that accepts `casStrobe`, with `rdData` valid in that cycle. A write never raises `rdValid`.
- R6: `hostReady` is 0 for one cycle after a row strobe is accepted and then 1 while the row is open. It is 0 for the two cycles after a column strobe is accepted (data phase and write-back phase) and returns to 1 in the following idle cycle, unless a refresh is due.
- R7: A refresh falls due every REF_INTERVAL cycles. When the controller is idle, each refresh holds `hostReady` at 0 for exactly 3 cycles (due, load, write-back).
- R8: Refresh steps through the rows in order, reloading and writing back each one, so stored data survives any length of idle time.
- R9: A refresh that falls due while a row is open waits. `hostReady` stays 1 throughout the open phase, the access completes correctly, and the pending refresh takes the idle cycle right after write-back before any new row strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| muxAddr | input | max(ROW_W,COL_W) | Shared address bus: row index under rasStrobe, column index under casStrobe |
| rasStrobe | input | 1 | Row strobe / request valid for the row phase |
| casStrobe | input | 1 | Column strobe / request valid for the column phase |
| hostWrite | input | 1 | 1 = write, 0 = read; sampled with casStrobe |
| wrData | input | DATA_W | Write word, sampled with casStrobe |
| hostReady | output | 1 | Controller accepts the next strobe |
| rdData | output | DATA_W | Read word |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |

## Verification
The bench writes a distinct arithmetic pattern into every word of a small array and then reads it all back twice. A controller that skipped the write-back after a destructive load would return zero on the second pass. Overwriting one column per row and re-reading all columns exposes a merge that disturbs neighbouring bits or slices at the wrong offset. A long idle stretch that covers every row several times, followed by a full readback, catches refresh that loads without restoring or that skips rows. Holding a row open beyond the refresh interval catches a refresh that cuts into an access (the data would be lost) and one that is never served (no ready gap would follow).

// File: rtl/dram_rb_pkg.sv
package dram_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_OPEN,
    ST_DATA,
    ST_WB,
    ST_REF_LD,
    ST_REF_WB
  } ctrl_state_t;

  typedef struct packed {
    logic latchRow;
    logic loadRow;
    logic latchCol;
    logic readOut;
    logic mergeWr;
    logic writeBack;
    logic selRefresh;
  } dram_strobe_t;

endpackage

// File: rtl/dram_rb_ctrl.sv
module dram_rb_ctrl
  import dram_rb_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int REF_INTERVAL = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rasStrobe,
  input  logic             casStrobe,
  input  logic             hostWrite,
  output logic             hostReady,
  output dram_strobe_t     strb,
  output logic [ROW_W-1:0] refRow
);

  localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_INTERVAL - 1);

  ctrl_state_t state, stateNext;
  logic [CNT_W-1:0] refCnt;
  logic refPending;
  logic isWrite;

  // interval timer: free running, raises a pending flag once per interval
  always_ff @(posedge clk) begin
    if (rst) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (refCnt == CNT_LAST) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
        if (state == ST_IDLE && refPending) refPending <= 1'b0;
      end
    end
  end

  // next state
  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (refPending)     stateNext = ST_REF_LD;
        else if (rasStrobe) stateNext = ST_ACT;
      end
      ST_ACT:    stateNext = ST_OPEN;
      ST_OPEN:   if (casStrobe) stateNext = ST_DATA;
      ST_DATA:   stateNext = ST_WB;
      ST_WB:     stateNext = ST_IDLE;
      ST_REF_LD: stateNext = ST_REF_WB;
      ST_REF_WB: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      refRow  <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_OPEN && casStrobe) isWrite <= hostWrite;
      if (state == ST_REF_WB) refRow <= refRow + 1'b1;
    end
  end

  // strobes to the datapath
  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: strb.latchRow = !refPending && rasStrobe;
      ST_ACT:  strb.loadRow  = 1'b1;
      ST_OPEN: strb.latchCol = casStrobe;
      ST_DATA: begin
        strb.mergeWr = isWrite;
        strb.readOut = !isWrite;
      end
      ST_WB:   strb.writeBack = 1'b1;
      ST_REF_LD: begin
        strb.loadRow    = 1'b1;
        strb.selRefresh = 1'b1;
      end
      ST_REF_WB: begin
        strb.writeBack  = 1'b1;
        strb.selRefresh = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  assign hostReady = (state == ST_IDLE && !refPending) || (state == ST_OPEN);

endmodule

// File: rtl/dram_rb_datapath.sv
module dram_rb_datapath
  import dram_rb_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 4,
  parameter int MUX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dram_strobe_t      strb,
  input  logic [MUX_W-1:0]  muxAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ROW_W-1:0]  refRow,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int NROWS = 1 << ROW_W;
  localparam int NCOLS = 1 << COL_W;
  localparam int BUF_W = DATA_W * NCOLS;

  logic [BUF_W-1:0]  cellArray [NROWS];
  logic [BUF_W-1:0]  rowBuf, nextBuf, mergedBuf;
  logic [ROW_W-1:0]  rowReg, arrIdx;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wrReg, readWord;

  // address and write-data capture from the shared bus
  always_ff @(posedge clk) begin
    if (rst) begin
      rowReg <= '0;
      colReg <= '0;
      wrReg  <= '0;
    end else begin
      if (strb.latchRow) rowReg <= muxAddr[ROW_W-1:0];
      if (strb.latchCol) begin
        colReg <= muxAddr[COL_W-1:0];
        wrReg  <= wrData;
      end
    end
  end

  assign arrIdx = strb.selRefresh ? refRow : rowReg;

  // merge the write word into its column slice
  for (genvar c = 0; c < NCOLS; c++) begin : g_merge
    assign mergedBuf[c*DATA_W +: DATA_W] =
      (colReg == COL_W'(c)) ? wrReg : rowBuf[c*DATA_W +: DATA_W];
  end

  // one wide mux per output bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_rdmux
    logic [NCOLS-1:0] lane;
    for (genvar c = 0; c < NCOLS; c++) begin : g_lane
      assign lane[c] = rowBuf[c*DATA_W + b];
    end
    assign readWord[b] = lane[colReg];
  end

  always_comb begin
    if (strb.loadRow)      nextBuf = cellArray[arrIdx];
    else if (strb.mergeWr) nextBuf = mergedBuf;
    else                   nextBuf = rowBuf;
  end

  // behavioural array: a row load empties the row
  always_ff @(posedge clk) begin
    rowBuf <= nextBuf;
    if (strb.loadRow)   cellArray[arrIdx] <= '0;
    if (strb.writeBack) cellArray[arrIdx] <= rowBuf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.readOut;
      if (strb.readOut) rdData <= readWord;
    end
  end

endmodule

// File: rtl/dram_rb_top.sv
module dram_rb_top
  import dram_rb_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 64,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MUX_W-1:0]  muxAddr,
  input  logic              rasStrobe,
  input  logic              casStrobe,
  input  logic              hostWrite,
  input  logic [DATA_W-1:0] wrData,
  output logic              hostReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  dram_strobe_t     strb;
  logic [ROW_W-1:0] refRow;

  dram_rb_ctrl #(
    .ROW_W(ROW_W),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .rasStrobe(rasStrobe),
    .casStrobe(casStrobe),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .strb(strb),
    .refRow(refRow)
  );

  dram_rb_datapath #(
    .ROW_W(ROW_W),
    .COL_W(COL_W),
    .DATA_W(DATA_W),
    .MUX_W(MUX_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .muxAddr(muxAddr),
    .wrData(wrData),
    .refRow(refRow),
    .rdData(rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/dram_rb_checker.sv
module dram_rb_checker
  import dram_rb_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input dram_strobe_t strb,
  input logic         hostReady,
  input logic         rdValid
);

  logic rowOpen;

  always_ff @(posedge clk) begin
    if (rst)                 rowOpen <= 1'b0;
    else if (strb.loadRow)   rowOpen <= 1'b1;
    else if (strb.writeBack) rowOpen <= 1'b0;
  end

  a_r3_single_open_row: assert property (@(posedge clk) disable iff (rst)
    strb.loadRow |-> !rowOpen);

  a_r3_wb_needs_open: assert property (@(posedge clk) disable iff (rst)
    strb.writeBack |-> rowOpen);

  a_r5_rdvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  a_r6_busy_in_wb: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !hostReady);

  a_r7_refresh_restores: assert property (@(posedge clk) disable iff (rst)
    (strb.loadRow && strb.selRefresh) |=> (strb.writeBack && strb.selRefresh));

endmodule

bind dram_rb_top dram_rb_checker u_chk (
  .clk(clk),
  .rst(rst),
  .strb(strb),
  .hostReady(hostReady),
  .rdValid(rdValid)
);

// File: tb/dram_rb_top_test.sv
module dram_rb_top_test;

  localparam int ROW_W = 3;
  localparam int COL_W = 2;
  localparam int DATA_W = 4;
  localparam int REF_INTERVAL = 20;
  localparam int MUX_W = 3;
  localparam int NROWS = 1 << ROW_W;
  localparam int NCOLS = 1 << COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MUX_W-1:0] muxAddr = '0;
  logic rasStrobe = 1'b0;
  logic casStrobe = 1'b0;
  logic hostWrite = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic hostReady;
  logic [DATA_W-1:0] rdData;
  logic rdValid;

  int nChecks = 0;
  int nFails = 0;
  int holdLow = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_rb_top #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REF_INTERVAL(REF_INTERVAL)
  ) uut (
    .clk(clk), .rst(rst), .muxAddr(muxAddr), .rasStrobe(rasStrobe),
    .casStrobe(casStrobe), .hostWrite(hostWrite), .wrData(wrData),
    .hostReady(hostReady), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat1(input int r, input int c);
    return DATA_W'((r * 5 + c * 3 + 7) % 16);
  endfunction

  function automatic logic [DATA_W-1:0] pat2(input int r, input int c);
    return ~pat1(r, c);
  endfunction

  task automatic access(input int row, input int col, input bit wr,
                        input logic [DATA_W-1:0] d, input int hold,
                        input bit chkT, output logic [DATA_W-1:0] q);
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    rasStrobe = 1'b1;
    muxAddr = MUX_W'(row);
    @(negedge clk);
    rasStrobe = 1'b0;
    if (chkT) check(hostReady == 1'b0, "R6 busy after row strobe", hostReady, 0);
    @(negedge clk);
    if (chkT) check(hostReady == 1'b1, "R6 ready while open", hostReady, 1);
    while (!hostReady) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!hostReady) holdLow++;
    end
    casStrobe = 1'b1;
    hostWrite = wr;
    muxAddr = MUX_W'(col);
    wrData = d;
    @(negedge clk);
    casStrobe = 1'b0;
    if (chkT) check(hostReady == 1'b0, "R6 busy in data phase", hostReady, 0);
    @(negedge clk);
    q = rdData;
    check(rdValid == !wr, "R5 rdValid in data cycle", rdValid, !wr);
    if (chkT) check(hostReady == 1'b0, "R6 busy in write-back", hostReady, 0);
    @(negedge clk);
    check(rdValid == 1'b0, "R5 rdValid single pulse", rdValid, 0);
    if (chkT) check(hostReady == 1'b1, "R6 ready after write-back", hostReady, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] q;
    int lastFall, runLen, nFalls;
    bit prevReady, inRun;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(hostReady == 1'b1, "R1 ready after reset", hostReady, 1);
    check(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);

    // R6 timing on the first access, before any refresh is due
    access(5, 2, 1'b1, 4'hA, 0, 1'b1, q);

    // R2 R4: fill the whole array
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < NCOLS; c++)
        access(r, c, 1'b1, pat1(r, c), 0, 1'b0, q);

    // R2 R3: read everything twice (destructive load must be restored)
    for (int pass = 0; pass < 2; pass++)
      for (int r = 0; r < NROWS; r++)
        for (int c = 0; c < NCOLS; c++) begin
          access(r, c, 1'b0, '0, 0, 1'b0, q);
          check(q == pat1(r, c), pass == 0 ? "R2 readback" : "R3 second read", q, pat1(r, c));
        end

    // R4: overwrite one column per row, neighbours must survive
    for (int r = 0; r < NROWS; r++)
      access(r, r % NCOLS, 1'b1, pat2(r, r % NCOLS), 0, 1'b0, q);
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < NCOLS; c++) begin
        logic [DATA_W-1:0] e;
        e = (c == r % NCOLS) ? pat2(r, c) : pat1(r, c);
        access(r, c, 1'b0, '0, 0, 1'b0, q);
        check(q == e, "R4 merge", q, e);
      end

    // R7: idle window, measure refresh gaps and periods
    lastFall = -1;
    runLen = 0;
    nFalls = 0;
    inRun = 1'b0;
    @(negedge clk);
    prevReady = hostReady;
    for (int t = 0; t < NROWS * REF_INTERVAL * 3; t++) begin
      @(negedge clk);
      if (prevReady && !hostReady) begin
        if (lastFall >= 0)
          check(t - lastFall == REF_INTERVAL, "R7 refresh period", t - lastFall, REF_INTERVAL);
        lastFall = t;
        nFalls++;
        inRun = 1'b1;
        runLen = 0;
      end
      if (inRun && !hostReady) runLen++;
      if (inRun && hostReady) begin
        check(runLen == 3, "R7 refresh busy length", runLen, 3);
        inRun = 1'b0;
      end
      prevReady = hostReady;
    end
    check(nFalls >= NROWS * 3 - 1, "R7 refresh count", nFalls, NROWS * 3 - 1);

    // R8: data survives refresh-only period
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < NCOLS; c++) begin
        logic [DATA_W-1:0] e;
        e = (c == r % NCOLS) ? pat2(r, c) : pat1(r, c);
        access(r, c, 1'b0, '0, 0, 1'b0, q);
        check(q == e, "R8 refresh retains", q, e);
      end

    // R9: hold a row open past the refresh interval
    holdLow = 0;
    access(3, 1, 1'b0, '0, REF_INTERVAL + 10, 1'b0, q);
    check(holdLow == 0, "R9 ready held while open", holdLow, 0);
    check(q == pat1(3, 1), "R9 data after long open", q, pat1(3, 1));
    check(hostReady == 1'b0, "R9 pending refresh served after write-back", hostReady, 0);
    access(3, 1, 1'b0, '0, 0, 1'b0, q);
    check(q == pat1(3, 1), "R9 data after deferred refresh", q, pat1(3, 1));

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule